// File: doc/BRIEF.md
# DRAM Parallel Test Mode Logic

This block models the device-side control that puts a fast-page-mode DRAM into its compressed parallel test and takes it out again. It samples the active-low RAS, CAS and WE strobes on a system clock and classifies each RAS cycle at the moment RAS goes low. If CAS and WE are both already low at that moment, the cycle is a test-entry cycle. If CAS is low and WE is high, the cycle is a CAS-before-RAS refresh. If CAS is high, the cycle opens a row. A row cycle that ends with no CAS pulse inside it is a RAS-only refresh.

The test mode is held in a flag. The flag stays set until one of the two refresh-type cycles clears it. While the flag is set, a read compresses each group of four internal bits into a single pass/fail level per data pin. The two low column address bits then have no effect. In normal mode the same two bits pick one bit of each group. A test-mode read takes extra clock cycles compared with a normal read. The memory array, analog timing and tristate behaviour are outside this block.

Top module: `dram_ptest_ctrl`

## Requirements
- R1: After reset, `test_mode` is 0 and `dq_valid` is 0.
- R2: A clock edge at which `ras_n` goes from 1 to 0 while `cas_n`=0 and `we_n`=0 sets `test_mode` to 1 from the next cycle.
- R3: Once set, `test_mode` stays set through row cycles (RAS falls with `cas_n`=1, then CAS pulses) and through further entry cycles.
- R4: A RAS fall with `cas_n`=0 and `we_n`=1 (CAS-before-RAS refresh) clears `test_mode`.
- R5: A RAS rise that ends a row cycle in which CAS never fell (RAS-only refresh) clears `test_mode`.
- R6: In normal mode, a read happens when CAS falls inside a row cycle with `we_n`=1. For that read, `dq[i]` = `cell_bits[4*i + col_sel]`.
- R7: In test mode, a read sets `dq[i]` to 1 when the four bits `cell_bits[4*i+3:4*i]` are all equal, and to 0 when any of them differ.
- R8: In test mode, the value of `col_sel` does not change the read result.
- R9: The inputs of a read are sampled at the CAS-fall clock edge k. `dq_valid` is high for exactly one cycle, after edge k+ACC_LAT-1 for a normal read and after edge k+ACC_LAT+TEST_EXTRA-1 for a test read. With the default values these are edges k+1 and k+2.
- R10: A CAS fall with `we_n`=0 (write), and any refresh or entry cycle, produces no `dq_valid` pulse in either mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the strobes |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| col_sel | input | 2 | Two low column address bits |
| cell_bits | input | 4*NUM_DQ | Four internal read bits per data pin; group i is bits 4i+3..4i |
| dq | output | NUM_DQ | Read result per data pin, 0 when not valid |
| dq_valid | output | 1 | One-cycle strobe marking a read result on `dq` |
| test_mode | output | 1 | Latched test-mode flag |

## Verification
The hardest case to reach from the ports is the RAS-only exit. It depends on what happened inside the whole row cycle, not on the strobes at a single edge, so a row cycle with CAS pulses must be told apart from one without. The stimulus covers both. It runs page-mode row cycles with reads and writes in test mode and checks that the flag survives them. It then runs a bare RAS pulse and checks that the flag clears. A scoreboard holds each read's expected value and expected arrival cycle. Any pulse from a write or refresh therefore shows up as an unexpected item, and a read that lands one cycle early or late also fails.

// File: rtl/dram_ptest_ctrl.sv
module dram_ptest_ctrl #(
  parameter int NUM_DQ     = 4,
  parameter int ACC_LAT    = 2,
  parameter int TEST_EXTRA = 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ras_n,
  input  logic                  cas_n,
  input  logic                  we_n,
  input  logic [1:0]            col_sel,
  input  logic [4*NUM_DQ-1:0]   cell_bits,
  output logic [NUM_DQ-1:0]     dq,
  output logic                  dq_valid,
  output logic                  test_mode
);
  localparam int STAGES = ACC_LAT + TEST_EXTRA;
  localparam int NORM_IN = TEST_EXTRA;

  logic ras_q, cas_q;
  logic row_open, cas_seen;
  logic ras_fall, ras_rise, cas_fall, rd_go;
  logic [NUM_DQ-1:0] rd_val;
  logic [STAGES-1:0] pv;
  logic [NUM_DQ-1:0] pd [STAGES];

  assign ras_fall = ras_q & ~ras_n;
  assign ras_rise = ~ras_q & ras_n;
  assign cas_fall = cas_q & ~cas_n & ~ras_n & row_open;
  assign rd_go    = cas_fall & we_n;

  always_comb begin
    for (int i = 0; i < NUM_DQ; i++) begin
      logic [3:0] grp;
      grp = cell_bits[4*i +: 4];
      rd_val[i] = test_mode ? ((&grp) | ~(|grp)) : grp[col_sel];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q <= 1'b1;
      cas_q <= 1'b1;
      row_open <= 1'b0;
      cas_seen <= 1'b0;
      test_mode <= 1'b0;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fall) begin
        row_open <= cas_n;
        cas_seen <= 1'b0;
        if (!cas_n) test_mode <= ~we_n;
      end else if (ras_rise) begin
        row_open <= 1'b0;
        if (row_open && !cas_seen) test_mode <= 1'b0;
      end else if (cas_fall) begin
        cas_seen <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pv <= '0;
      for (int i = 0; i < STAGES; i++) pd[i] <= '0;
    end else begin
      pv[0] <= 1'b0;
      for (int i = 1; i < STAGES; i++) begin
        pv[i] <= pv[i-1];
        pd[i] <= pd[i-1];
      end
      if (rd_go) begin
        if (test_mode) begin
          pv[0] <= 1'b1;
          pd[0] <= rd_val;
        end else begin
          pv[NORM_IN] <= 1'b1;
          pd[NORM_IN] <= rd_val;
        end
      end
    end
  end

  assign dq_valid = pv[STAGES-1];
  assign dq       = pv[STAGES-1] ? pd[STAGES-1] : '0;

  AST_ENTRY: assert property (@(posedge clk) disable iff (!rst_n) (ras_fall && !cas_n && !we_n) |=> test_mode); // R2
  AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!ras_fall && !ras_rise) |=> $stable(test_mode)); // R3
  AST_CBR_EXIT: assert property (@(posedge clk) disable iff (!rst_n) (ras_fall && !cas_n && we_n) |=> !test_mode); // R4
  AST_RAS_ONLY_EXIT: assert property (@(posedge clk) disable iff (!rst_n) (ras_rise && row_open && !cas_seen) |=> !test_mode); // R5
  AST_NO_WRITE_DATA: assert property (@(posedge clk) disable iff (!rst_n) (cas_fall && !we_n && test_mode) |=> !pv[0]); // R10
  AST_IDLE_DQ: assert property (@(posedge clk) disable iff (!rst_n) !dq_valid |-> (dq == '0)); // R9
endmodule

// File: tb/dram_ptest_ctrl_bench.sv
module dram_ptest_ctrl_bench;
  localparam int NUM_DQ = 4;
  localparam int ACC_LAT = 2;
  localparam int TEST_EXTRA = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] col_sel = 2'd0;
  logic [4*NUM_DQ-1:0] cell_bits = '0;
  logic [NUM_DQ-1:0] dq;
  logic dq_valid, test_mode;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  bit model_tm = 1'b0;
  bit done = 1'b0;

  int    q_dq[$];
  int    q_cyc[$];
  string q_tag[$];

  dram_ptest_ctrl #(.NUM_DQ(NUM_DQ), .ACC_LAT(ACC_LAT), .TEST_EXTRA(TEST_EXTRA)) u_dram_ptest_ctrl (
    .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
    .col_sel(col_sel), .cell_bits(cell_bits), .dq(dq), .dq_valid(dq_valid), .test_mode(test_mode)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NUM_DQ-1:0] expect_val(input bit tm, input logic [1:0] c, input logic [4*NUM_DQ-1:0] cells);
    logic [NUM_DQ-1:0] r;
    for (int i = 0; i < NUM_DQ; i++) begin
      logic [3:0] g;
      g = cells[4*i +: 4];
      r[i] = tm ? (g == 4'hF || g == 4'h0) : g[c];
    end
    return r;
  endfunction

  always @(negedge clk) begin
    if (rst_n && dq_valid) begin
      if (q_dq.size() == 0) begin
        check(1'b0, "R10 unexpected dq_valid", int'(dq), 0);
      end else begin
        int e_dq, e_cyc;
        string t;
        e_dq = q_dq.pop_front();
        e_cyc = q_cyc.pop_front();
        t = q_tag.pop_front();
        check(int'(dq) == e_dq, t, int'(dq), e_dq);
        check(cyc == e_cyc, "R9 arrival cycle", cyc, e_cyc);
      end
    end
  end

  task automatic flag_check(input bit exp, input string tag);
    check(test_mode == exp, tag, int'(test_mode), int'(exp));
  endtask

  task automatic refresh_cas(input bit wr);
    @(negedge clk); cas_n = 1'b0; we_n = wr ? 1'b0 : 1'b1;
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk); ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    model_tm = wr;
  endtask

  task automatic ras_only();
    @(negedge clk); ras_n = 1'b0;
    @(negedge clk);
    @(negedge clk); ras_n = 1'b1;
    @(negedge clk);
    model_tm = 1'b0;
  endtask

  task automatic row_open_t();
    @(negedge clk); ras_n = 1'b0;
  endtask

  task automatic row_close();
    @(negedge clk); ras_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic col_cycle(input bit wr, input logic [1:0] c, input logic [4*NUM_DQ-1:0] cells, input string tag);
    @(negedge clk);
    col_sel = c; cell_bits = cells; we_n = wr ? 1'b0 : 1'b1; cas_n = 1'b0;
    if (!wr) begin
      q_dq.push_back(int'(expect_val(model_tm, c, cells)));
      q_cyc.push_back(cyc + (model_tm ? ACC_LAT + TEST_EXTRA : ACC_LAT));
      q_tag.push_back(tag);
    end
    @(negedge clk); cas_n = 1'b1; we_n = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(test_mode == 1'b0 && dq_valid == 1'b0, "R1 reset state", {test_mode, dq_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(test_mode == 1'b0 && dq_valid == 1'b0, "R1 after release", {test_mode, dq_valid}, 0);

    row_open_t();
    col_cycle(1'b0, 2'd0, 16'hA5C3, "R6 normal col0");
    col_cycle(1'b0, 2'd1, 16'hA5C3, "R6 normal col1");
    col_cycle(1'b1, 2'd2, 16'hFFFF, "R10 write");
    col_cycle(1'b0, 2'd2, 16'h1E87, "R6 normal col2");
    col_cycle(1'b0, 2'd3, 16'h1E87, "R6 normal col3");
    row_close();
    repeat (4) @(negedge clk);
    flag_check(1'b0, "R6 normal rows keep flag clear");

    refresh_cas(1'b0);
    flag_check(1'b0, "R4 refresh in normal mode");
    ras_only();
    flag_check(1'b0, "R5 ras-only in normal mode");

    refresh_cas(1'b1);
    flag_check(1'b1, "R2 entry cycle");

    row_open_t();
    col_cycle(1'b0, 2'd0, 16'hF00F, "R7 all equal groups");
    col_cycle(1'b0, 2'd1, 16'h1248, "R7 all differing groups");
    col_cycle(1'b0, 2'd2, 16'hF0E1, "R7 mixed groups");
    col_cycle(1'b1, 2'd0, 16'h0000, "R10 test write");
    col_cycle(1'b0, 2'd3, 16'hF0E1, "R8 col ignored 3");
    col_cycle(1'b0, 2'd1, 16'hF0E1, "R8 col ignored 1");
    row_close();
    repeat (4) @(negedge clk);
    flag_check(1'b1, "R3 flag held through row cycle");

    refresh_cas(1'b1);
    flag_check(1'b1, "R3 flag held through re-entry");

    refresh_cas(1'b0);
    flag_check(1'b0, "R4 refresh exit");

    row_open_t();
    col_cycle(1'b0, 2'd2, 16'hF0E1, "R6 normal after exit");
    row_close();

    refresh_cas(1'b1);
    flag_check(1'b1, "R2 second entry");
    ras_only();
    flag_check(1'b0, "R5 ras-only exit");

    row_open_t();
    col_cycle(1'b0, 2'd3, 16'h8421, "R6 normal after ras-only exit");
    row_close();

    repeat (6) @(negedge clk);
    check(q_dq.size() == 0, "R9 missing outputs", q_dq.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule